// File: doc/BRIEF.md
# Real-Time Clock Register Port with CMOS Byte Store

This block puts a clock-and-calendar with 128 bytes of battery-style storage behind a byte-wide bus of only two addresses. Software first writes a location number to the pointer address. It then reads or writes that location through the window address. The same pointer write also sets an output that masks the non-maskable interrupt.

Eight locations are not storage. They show the live calendar: seconds, minutes, hours, weekday, day, month, two-digit year and century, each as packed BCD. Writing one of them with a BCD byte sets that calendar field. The calendar moves forward by one second on each pulse of `sec_tick`. It handles the 24-hour day, month lengths and Gregorian leap years. Two status locations are read-only, and one of them reports at reset that the clock and storage are valid. Every other location is a plain byte of storage.

Top module: `cmos_clock_port`

## Requirements
- R1: A bus write with `addr`=0 loads the pointer from `wdata[6:0]` and drives `nmi_mask` from `wdata[7]`. Both take effect from the cycle after the write. `nmi_mask` is 0 after reset.
- R2: A bus read with `addr`=0 returns 0x00. It changes neither the pointer nor `nmi_mask`.
- R3: `rdata` is 0x00 after reset. It is loaded at the clock edge where `cs`=1 and `we`=0, and it holds its value in every other cycle.
- R4: The calendar sits at these pointer values: 0x00 seconds, 0x02 minutes, 0x04 hours (0–23), 0x06 weekday, 0x07 day of month, 0x08 month (1–12), 0x09 year, 0x32 century. Each reads as packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. After reset the calendar reads 2000-01-01 00:00:00, weekday 7.
- R5: The weekday runs from 1 to 7, with Sunday as 1. It advances at each midnight and goes from 7 back to 1.
- R6: The year location holds the year modulo 100 and the century location holds the year divided by 100. A year rollover from 99 to 00 adds one to the century.
- R7: Locations 0x0C and 0x0D are read-only, and window writes to them are ignored. 0x0C reads 0x00. 0x0D reads 0x80, which is the valid flag in bit 7, set at reset.
- R8: Every other location is a storage byte. It reads 0x00 after reset and returns the last byte written to it.
- R9: A window write to a calendar location sets that field to the value of the BCD byte written.
- R10: Each `sec_tick` pulse adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R11: The day of month wraps after the last day of its month and carries into the month. February has 29 days when the year is divisible by 4, except century years not divisible by 400 (2000 is a leap year, 2100 is not). December wraps to January and carries into the year.
- R12: If a window write to a calendar location and a `sec_tick` pulse arrive in the same cycle, the write is applied and that tick is dropped for the whole calendar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = pointer, 1 = data window |
| wdata | input | 8 | Write data |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| rdata | output | 8 | Registered read data |
| nmi_mask | output | 1 | Interrupt mask bit from the last pointer write |

## Verification
The hardest cases to reach are the cascades where a single tick carries through every field. Examples are the change into a new century and the end of February in years such as 2100 and 2000. Counting ticks would take millions of cycles to get there. The stimulus instead loads the calendar through the data window to one second before each boundary, sends one tick, and reads every field back. Random traffic then mixes pointer writes, storage accesses, calendar loads and ticks, some of which land in the same cycle as a load. A bench model predicts every read.

// File: rtl/cmos_clock_pkg.sv
`timescale 1ns/1ps
package cmos_clock_pkg;

  localparam logic [6:0] IX_SEC  = 7'h00;
  localparam logic [6:0] IX_MIN  = 7'h02;
  localparam logic [6:0] IX_HOUR = 7'h04;
  localparam logic [6:0] IX_WDAY = 7'h06;
  localparam logic [6:0] IX_MDAY = 7'h07;
  localparam logic [6:0] IX_MON  = 7'h08;
  localparam logic [6:0] IX_YEAR = 7'h09;
  localparam logic [6:0] IX_CENT = 7'h32;
  localparam logic [6:0] IX_STAT_C = 7'h0C;
  localparam logic [6:0] IX_STAT_D = 7'h0D;
  localparam logic [7:0] STAT_D_INIT = 8'h80;

  typedef enum logic [3:0] {
    F_SEC, F_MIN, F_HOUR, F_WDAY, F_MDAY, F_MON, F_YEAR, F_CENT, F_NONE
  } cal_field_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [6:0] wday;
    logic [6:0] mday;
    logic [6:0] mon;
    logic [6:0] year;
    logic [6:0] cent;
  } cal_t;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [3:0] t;
    logic [3:0] u;
    t = 4'(v / 7'd10);
    u = 4'(v % 7'd10);
    return {t, u};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'({3'b000, b[7:4]}) * 7'd10 + 7'({3'b000, b[3:0]});
  endfunction

  // Binary fields: year % 4 is the two low bits; a 00 year defers to the century.
  function automatic logic leap_year(input logic [6:0] yr, input logic [6:0] ce);
    if (yr == 7'd0) return (ce[1:0] == 2'b00);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] m, input logic lp);
    case (m)
      7'd2:                      return lp ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

  function automatic cal_field_e field_of(input logic [6:0] ix);
    case (ix)
      IX_SEC:  return F_SEC;
      IX_MIN:  return F_MIN;
      IX_HOUR: return F_HOUR;
      IX_WDAY: return F_WDAY;
      IX_MDAY: return F_MDAY;
      IX_MON:  return F_MON;
      IX_YEAR: return F_YEAR;
      IX_CENT: return F_CENT;
      default: return F_NONE;
    endcase
  endfunction

  function automatic logic [6:0] cal_pick(input cal_t c, input cal_field_e f);
    case (f)
      F_SEC:   return c.sec;
      F_MIN:   return c.min;
      F_HOUR:  return c.hour;
      F_WDAY:  return c.wday;
      F_MDAY:  return c.mday;
      F_MON:   return c.mon;
      F_YEAR:  return c.year;
      F_CENT:  return c.cent;
      default: return 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/cmos_index_reg.sv
`timescale 1ns/1ps
module cmos_index_reg #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    din,
  output logic [IW-1:0] idx,
  output logic          nmi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      nmi <= 1'b0;
    end else if (wr) begin
      idx <= din[IW-1:0];
      nmi <= din[7];
    end
  end

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (idx == $past(din[IW-1:0])));
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(idx) && $stable(nmi)));
endmodule

// File: rtl/cmos_byte_store.sv
`timescale 1ns/1ps
module cmos_byte_store #(
  parameter int         DEPTH    = 128,
  parameter int         IW       = 7,
  parameter int         PRESET_IX = 13,
  parameter logic [7:0] PRESET_V = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [7:0]    wd,
  output logic [7:0]    rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i == PRESET_IX) ? PRESET_V : 8'h00;
    end else if (we) begin
      mem[addr] <= wd;
    end
  end

  assign rd = mem[addr];

  assert_store_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rd == $past(wd)) || (addr != $past(addr)));
endmodule

// File: rtl/cmos_calendar.sv
`timescale 1ns/1ps
module cmos_calendar
  import cmos_clock_pkg::*;
#(
  parameter int RST_CENT = 20,
  parameter int RST_WDAY = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ld_en,
  input  cal_field_e ld_sel,
  input  logic [6:0] ld_val,
  output cal_t       cal
);
  cal_t q;
  logic adv, lp;
  logic [6:0] dim;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;

  assign adv       = tick & ~ld_en;
  assign lp        = leap_year(q.year, q.cent);
  assign dim       = month_days(q.mon, lp);
  assign sec_wrap  = adv && (q.sec == 7'd59);
  assign min_wrap  = sec_wrap && (q.min == 7'd59);
  assign hour_wrap = min_wrap && (q.hour == 7'd23);
  assign day_wrap  = hour_wrap && (q.mday == dim);
  assign mon_wrap  = day_wrap && (q.mon == 7'd12);
  assign year_wrap = mon_wrap && (q.year == 7'd99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, wday: 7'(RST_WDAY),
             mday: 7'd1, mon: 7'd1, year: 7'd0, cent: 7'(RST_CENT)};
    end else if (ld_en) begin
      case (ld_sel)
        F_SEC:   q.sec  <= ld_val;
        F_MIN:   q.min  <= ld_val;
        F_HOUR:  q.hour <= ld_val;
        F_WDAY:  q.wday <= ld_val;
        F_MDAY:  q.mday <= ld_val;
        F_MON:   q.mon  <= ld_val;
        F_YEAR:  q.year <= ld_val;
        F_CENT:  q.cent <= ld_val;
        default: ;
      endcase
    end else if (adv) begin
      q.sec <= sec_wrap ? 7'd0 : q.sec + 7'd1;
      if (sec_wrap)  q.min  <= min_wrap ? 7'd0 : q.min + 7'd1;
      if (min_wrap)  q.hour <= hour_wrap ? 7'd0 : q.hour + 7'd1;
      if (hour_wrap) begin
        q.wday <= (q.wday == 7'd7) ? 7'd1 : q.wday + 7'd1;
        q.mday <= day_wrap ? 7'd1 : q.mday + 7'd1;
      end
      if (day_wrap)  q.mon  <= mon_wrap ? 7'd1 : q.mon + 7'd1;
      if (mon_wrap)  q.year <= year_wrap ? 7'd0 : q.year + 7'd1;
      if (year_wrap) q.cent <= (q.cent == 7'd99) ? 7'd0 : q.cent + 7'd1;
    end
  end

  assign cal = q;

  assert_sec_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && q.sec != 7'd59) |=> (q.sec == $past(q.sec) + 7'd1));
  assert_sec_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (q.sec == 7'd0));
  assert_wday_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_wrap && q.wday == 7'd7) |=> (q.wday == 7'd1));
  assert_feb_leap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_wrap && q.mon == 7'd2 && q.mday == 7'd28 && lp) |=> (q.mday == 7'd29));
  assert_century_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> (q.year == 7'd0) &&
      (q.cent == (($past(q.cent) == 7'd99) ? 7'd0 : $past(q.cent) + 7'd1)));
  assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel != F_SEC) |=> $stable(q.sec));
endmodule

// File: rtl/cmos_clock_port.sv
`timescale 1ns/1ps
module cmos_clock_port
  import cmos_clock_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int RST_CENT = 20,
  parameter int RST_WDAY = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       sec_tick,
  output logic [7:0] rdata,
  output logic       nmi_mask
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] idx;
  logic          ptr_wr, win_wr, rd_stb, ro_hit, store_we, cal_ld;
  logic [7:0]    store_rd, read_val;
  cal_field_e    fld;
  cal_t          cal;

  assign ptr_wr   = cs & we & ~addr;
  assign win_wr   = cs & we & addr;
  assign rd_stb   = cs & ~we;
  assign fld      = field_of(7'(idx));
  assign ro_hit   = (7'(idx) == IX_STAT_C) || (7'(idx) == IX_STAT_D);
  assign store_we = win_wr && (fld == F_NONE) && !ro_hit;
  assign cal_ld   = win_wr && (fld != F_NONE);

  cmos_index_reg #(.IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr(ptr_wr), .din(wdata),
    .idx(idx), .nmi(nmi_mask)
  );

  cmos_byte_store #(.DEPTH(DEPTH), .IW(IW), .PRESET_IX(int'(IX_STAT_D)),
                    .PRESET_V(STAT_D_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .addr(idx), .wd(wdata),
    .rd(store_rd)
  );

  cmos_calendar #(.RST_CENT(RST_CENT), .RST_WDAY(RST_WDAY)) u_cal (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .ld_en(cal_ld),
    .ld_sel(fld), .ld_val(from_bcd(wdata)), .cal(cal)
  );

  assign read_val = (fld != F_NONE) ? to_bcd(cal_pick(cal, fld)) : store_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= 8'h00;
    else if (rd_stb) rdata <= addr ? read_val : 8'h00;
  end

  assert_nmi_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (nmi_mask == $past(wdata[7])));
  assert_ptr_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !addr) |=> (rdata == 8'h00) && $stable(nmi_mask));
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata));
  assert_status_d_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr && 7'(idx) == IX_STAT_D) |=> (rdata == STAT_D_INIT));
endmodule

// File: tb/cmos_clock_port_test.sv
`timescale 1ns/1ps
module cmos_clock_port_test;
  logic clk = 0, rst_n = 0, cs = 0, we = 0, addr = 0, sec_tick = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic nmi_mask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmos_clock_port uut (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .sec_tick(sec_tick), .rdata(rdata), .nmi_mask(nmi_mask));

  // bench model
  int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year, m_cent;
  int m_idx;
  bit m_nmi;
  byte unsigned m_mem [128];

  function automatic byte unsigned bcd(int v);
    return byte'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int last_day(int mon, int full_year);
    bit lp = ((full_year % 4) == 0) && (((full_year % 100) != 0) || ((full_year % 400) == 0));
    if (mon == 2) return lp ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic bit is_cal(int i);
    return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9 || i == 'h32;
  endfunction

  task automatic model_tick();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0;
          m_wday = (m_wday % 7) + 1;
          m_mday++;
          if (m_mday > last_day(m_mon, m_cent * 100 + m_year)) begin
            m_mday = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_year++;
              if (m_year == 100) begin m_year = 0; m_cent = (m_cent + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  function automatic byte unsigned model_read(int i);
    case (i)
      'h00: return bcd(m_sec);
      'h02: return bcd(m_min);
      'h04: return bcd(m_hour);
      'h06: return bcd(m_wday);
      'h07: return bcd(m_mday);
      'h08: return bcd(m_mon);
      'h09: return bcd(m_year);
      'h32: return bcd(m_cent);
      default: return m_mem[i];
    endcase
  endfunction

  task automatic model_load(int i, byte unsigned v);
    int b = (v >> 4) * 10 + (v & 15);
    case (i)
      'h00: m_sec = b;
      'h02: m_min = b;
      'h04: m_hour = b;
      'h06: m_wday = b;
      'h07: m_mday = b;
      'h08: m_mon = b;
      'h09: m_year = b;
      'h32: m_cent = b;
      default: ;
    endcase
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    cs = 0; we = 0; sec_tick = 0;
  endtask

  task automatic do_idx(int i, bit n);
    cs = 1; we = 1; addr = 0; wdata = {n, 7'(i)};
    step();
    m_idx = i; m_nmi = n;
    chk("R1 nmi_mask", {7'd0, nmi_mask}, {7'd0, m_nmi});
  endtask

  task automatic do_wr(byte unsigned v, bit t);
    cs = 1; we = 1; addr = 1; wdata = v; sec_tick = t;
    step();
    if (is_cal(m_idx)) model_load(m_idx, v);
    else begin
      if (m_idx != 'h0C && m_idx != 'h0D) m_mem[m_idx] = v;
      if (t) model_tick();
    end
  endtask

  task automatic do_rd(string tag, bit t);
    byte unsigned e = model_read(m_idx);
    cs = 1; we = 0; addr = 1; sec_tick = t;
    step();
    if (t) model_tick();
    chk(tag, rdata, e);
  endtask

  task automatic do_rd0();
    cs = 1; we = 0; addr = 0;
    step();
    chk("R2 pointer read", rdata, 8'h00);
    chk("R2 nmi kept", {7'd0, nmi_mask}, {7'd0, m_nmi});
  endtask

  task automatic do_tick();
    sec_tick = 1;
    step();
    model_tick();
  endtask

  task automatic lit(int i, logic [7:0] exp, string tag);
    do_idx(i, m_nmi);
    do_rd(tag, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic set_field(int i, byte unsigned v);
    do_idx(i, m_nmi);
    do_wr(v, 0);
  endtask

  task automatic set_time(int ce, int yr, int mo, int dy, int wd, int hr, int mi, int se);
    set_field('h32, bcd(ce)); set_field('h09, bcd(yr)); set_field('h08, bcd(mo));
    set_field('h07, bcd(dy)); set_field('h06, bcd(wd)); set_field('h04, bcd(hr));
    set_field('h02, bcd(mi)); set_field('h00, bcd(se));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_sec = 0; m_min = 0; m_hour = 0; m_wday = 7; m_mday = 1; m_mon = 1;
    m_year = 0; m_cent = 20; m_idx = 0; m_nmi = 0;
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    m_mem['h0D] = 8'h80;
    void'($urandom(32'h0c1c_2000));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // reset state
    chk("R3 rdata after reset", rdata, 8'h00);
    chk("R1 nmi after reset", {7'd0, nmi_mask}, 8'h00);
    lit('h0D, 8'h80, "R7 status D preset");
    lit('h0C, 8'h00, "R7 status C");
    lit('h00, 8'h00, "R4 seconds reset");
    lit('h32, 8'h20, "R6 century reset");
    lit('h06, 8'h07, "R5 weekday reset");
    lit('h08, 8'h01, "R4 month reset");
    lit('h10, 8'h00, "R8 store reset");

    // read-only status
    set_field('h0D, 8'h00); lit('h0D, 8'h80, "R7 D write ignored");
    set_field('h0C, 8'h5A); lit('h0C, 8'h00, "R7 C write ignored");

    // storage and pointer read
    do_idx('h10, 1);
    chk("R1 nmi set", {7'd0, nmi_mask}, 8'h01);
    do_wr(8'hA5, 0);
    do_rd0();
    do_rd("R2 pointer unchanged", 0);
    chk("R8 store readback", rdata, 8'hA5);
    cs = 0; step();
    chk("R3 rdata holds", rdata, 8'hA5);
    do_idx('h7F, 0); do_wr(8'h3C, 0); lit('h7F, 8'h3C, "R8 top byte");

    // load and century rollover
    set_field('h04, 8'h17); lit('h04, 8'h17, "R9 hour load");
    set_time(20, 99, 12, 31, 7, 23, 59, 59);
    do_tick();
    lit('h00, 8'h00, "R10 seconds wrap");
    lit('h02, 8'h00, "R10 minutes wrap");
    lit('h04, 8'h00, "R10 hours wrap");
    lit('h06, 8'h01, "R5 weekday 7 to 1");
    lit('h07, 8'h01, "R11 day wrap");
    lit('h08, 8'h01, "R11 month wrap");
    lit('h09, 8'h00, "R6 year wrap");
    lit('h32, 8'h21, "R6 century carry");

    // leap years
    set_time(20, 0, 2, 28, 2, 23, 59, 59); do_tick();
    lit('h07, 8'h29, "R11 2000 leap");
    set_time(21, 0, 2, 28, 2, 23, 59, 59); do_tick();
    lit('h07, 8'h01, "R11 2100 not leap"); lit('h08, 8'h03, "R11 2100 march");
    set_time(20, 24, 2, 29, 5, 23, 59, 59); do_tick();
    lit('h07, 8'h01, "R11 2024 feb 29 end"); lit('h08, 8'h03, "R11 2024 march");
    set_time(20, 23, 2, 28, 3, 23, 59, 59); do_tick();
    lit('h08, 8'h03, "R11 2023 no leap");
    set_time(20, 23, 4, 30, 1, 23, 59, 59); do_tick();
    lit('h07, 8'h01, "R11 april end"); lit('h08, 8'h05, "R11 may");

    // load and tick in one cycle
    set_time(20, 23, 6, 10, 1, 10, 20, 5);
    do_idx('h00, 0); do_wr(8'h30, 1);
    lit('h00, 8'h30, "R12 load wins");
    lit('h02, 8'h20, "R12 minutes untouched");
    do_idx('h02, 0); do_wr(8'h45, 1);
    lit('h00, 8'h30, "R12 tick dropped");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 10;
      bit t = ($urandom % 4) == 0;
      if (op < 2) begin
        int pick = $urandom % 12;
        int ix;
        case (pick)
          0: ix = 'h00; 1: ix = 'h02; 2: ix = 'h04; 3: ix = 'h06; 4: ix = 'h07;
          5: ix = 'h08; 6: ix = 'h09; 7: ix = 'h32; 8: ix = 'h0C; 9: ix = 'h0D;
          default: ix = $urandom % 128;
        endcase
        do_idx(ix, 1'($urandom));
      end else if (op < 4) begin
        byte unsigned v;
        case (m_idx)
          'h00, 'h02: v = bcd($urandom % 60);
          'h04: v = bcd($urandom % 24);
          'h06: v = bcd(1 + $urandom % 7);
          'h07: v = bcd(1 + $urandom % 28);
          'h08: v = (m_mday <= 28) ? bcd(1 + $urandom % 12) : bcd(m_mon);
          'h09, 'h32: v = bcd($urandom % 100);
          default: v = byte'($urandom);
        endcase
        do_wr(v, t);
      end else if (op < 7) begin
        do_rd("R4 R8 random read", t);
      end else if (op == 7) begin
        do_rd0();
      end else begin
        do_tick();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule